// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches a 16-bit free-running count supplied from outside, together with a one-cycle strobe that marks each cycle in which that count moves to a new value. It holds five independent 16-bit compare values. When an enabled channel's value equals the count on a strobe cycle, the unit latches a per-channel status flag. While any latched flag has its enable set, the unit raises an interrupt request.

Software uses a small byte-wide register window to program the block. Each compare value is split into a high byte and a low byte. A single enable byte holds the five channel enables, and a status byte holds the five flags. Each flag is cleared by writing a 1 to its bit. The count source, its prescaler and any pin actions sit outside this block.

Top module: `ocmp_top`

## Requirements
- R1: After reset, every compare byte reads 0xFF, the enable byte (address 0xA) and the flag byte (address 0xB) read 0x00, and `irq_o` is 0.
- R2: Channel k (k = 1..5) keeps its compare value in two bytes. The high byte is at address 2(k-1) and the low byte is at address 2(k-1)+1. A byte written with `wr_en_i` reads back unchanged from the next cycle on.
- R3: The enable byte at address 0xA holds channel 1 at bit 7, channel 2 at bit 6, and so on down to channel 5 at bit 3. Bits 2..0 are not stored and always read 0.
- R4: A clock edge sets a channel's flag when all three of these hold in that cycle: `cnt_step_i` is 1, `cnt_val_i` equals the channel's compare value, and the channel's enable bit is 1. The flag reads 1 from the following cycle.
- R5: A channel whose enable bit is 0 never sets its flag, even when the count equals its compare value on a strobe cycle.
- R6: No flag sets in a cycle where `cnt_step_i` is 0, even when the count equals a compare value and the channel is enabled.
- R7: The flag byte at address 0xB places each flag at the same bit position as its enable. Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R8: When a match and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` is 1 exactly when at least one flag and its enable bit are both 1. Clearing the enable bit drops `irq_o` and leaves the flag set.
- R10: A compare byte written in one cycle is the value matched against from the next cycle on. The value it replaced no longer matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cnt_val_i | input | 16 | Current free-running count value |
| cnt_step_i | input | 1 | High in the cycle in which the count has advanced to a new value |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- A flag rises only after a qualified match, and never without a count strobe or with its channel disabled.
- A written 1 clears a flag unless a match lands in the same cycle.
- Flags hold when nothing touches them.
- The interrupt is never raised with all enables off.

Other behaviours need the bench's scenarios to show them:
- The exact byte and bit positions of the register window.
- The reset values.
- A freshly written compare byte replacing the old value on the very next strobe.
- The interrupt falling when an enable is withdrawn while the flag stays set.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int BYTE_W = 8;

  // Bit position of channel idx (0-based) in the enable and flag bytes.
  function automatic int chan_bit(input int idx);
    return BYTE_W - 1 - idx;
  endfunction
endpackage

// File: rtl/ocmp_chan.sv
module ocmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [7:0]    wdata_i,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cmp_o,
  output logic          hit_o
);
  localparam int LO_W = CW - 8;

  logic [CW-1:0] cmp_q, cmp_d;
  logic          cmp_ce;

  // next state
  always_comb begin
    cmp_d  = cmp_q;
    cmp_ce = wr_hi_i | wr_lo_i;
    if (wr_hi_i) cmp_d[CW-1 -: 8]  = wdata_i;
    if (wr_lo_i) cmp_d[LO_W-1:0]   = wdata_i[LO_W-1:0];
  end

  // register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '1;
    else if (cmp_ce) cmp_q <= cmp_d;
  end

  assign cmp_o = cmp_q;
  assign hit_o = en_i & step_i & (cnt_i == cmp_q);

  // R5: disabled channel never reports a match
  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |-> !hit_o);
  // R6: no match without a count strobe
  assert_needs_step_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_i |-> !hit_o);
  // R10: a byte write is in the register on the next cycle
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_lo_i |=> (cmp_o[LO_W-1:0] == $past(wdata_i[LO_W-1:0])));
endmodule

// File: rtl/ocmp_flags.sv
module ocmp_flags #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] flags_o,
  output logic           irq_o
);
  logic [NCH-1:0] flags_q, flags_d;
  logic           flags_ce;

  // next state: a match wins over a write-1 clear
  always_comb begin
    flags_ce = |(set_i | clr_i);
    flags_d  = (flags_q & ~clr_i) | set_i;
  end

  // register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  // R4: a flag only rises after a qualified match
  assert_rise_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
  // R7: write-1 clears when no match competes
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((flags_q & $past(clr_i) & ~$past(set_i)) == '0));
  // R7: flags hold when neither set nor cleared
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> $stable(flags_q));
  // R8: a match always lands, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/ocmp_top.sv
module ocmp_top
  import ocmp_pkg::*;
#(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          cnt_step_i,
  output logic          irq_o
);
  localparam logic [AW-1:0] EN_ADDR   = AW'(2 * NCH);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2 * NCH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // enable register
  logic [NCH-1:0] en_q, en_d;
  logic           en_ce;

  always_comb begin
    en_ce = wr_en_i && (addr_i == EN_ADDR);
    en_d  = en_q;
    for (int i = 0; i < NCH; i++) en_d[i] = wdata_i[chan_bit(i)];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // compare channels
  logic [CW-1:0]  cmp_arr [NCH];
  logic [NCH-1:0] hit_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] flag_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic wr_hi, wr_lo;
    assign wr_hi = wr_en_i && (addr_i == AW'(2 * g));
    assign wr_lo = wr_en_i && (addr_i == AW'(2 * g + 1));
    assign clr_vec[g] = wr_en_i && (addr_i == FLAG_ADDR) && wdata_i[chan_bit(g)];

    ocmp_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_ni  (rst_int_n),
      .wr_hi_i (wr_hi),
      .wr_lo_i (wr_lo),
      .wdata_i (wdata_i),
      .en_i    (en_q[g]),
      .step_i  (cnt_step_i),
      .cnt_i   (cnt_val_i),
      .cmp_o   (cmp_arr[g]),
      .hit_o   (hit_vec[g])
    );
  end

  ocmp_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .set_i   (hit_vec),
    .clr_i   (clr_vec),
    .en_i    (en_q),
    .flags_o (flag_vec),
    .irq_o   (irq_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(2 * i))     rdata_o = cmp_arr[i][CW-1 -: 8];
      if (addr_i == AW'(2 * i + 1)) rdata_o = cmp_arr[i][7:0];
    end
    if (addr_i == EN_ADDR)
      for (int i = 0; i < NCH; i++) rdata_o[chan_bit(i)] = en_q[i];
    if (addr_i == FLAG_ADDR)
      for (int i = 0; i < NCH; i++) rdata_o[chan_bit(i)] = flag_vec[i];
  end

  // R9: no interrupt while every enable is off
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (en_q != '0));
  // R9: an interrupt implies a latched flag
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (flag_vec != '0));
endmodule

// File: tb/ocmp_top_tb_top.sv
module ocmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [3:0]  addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [15:0] cnt_val_i;
  logic        cnt_step_i;
  logic        irq_o;

  always #10 clk = ~clk;

  ocmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_val_i(cnt_val_i),
    .cnt_step_i(cnt_step_i), .irq_o(irq_o)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  logic  obs_valid = 1'b0;
  int    n_total = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // monitor: pops expected items and compares mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (obs_valid && exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? {7'd0, irq_o} : rdata_o;
        n_total++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    addr_i = a;
    exp_q.push_back(it);
    obs_valid = 1'b1;
    tick();
    obs_valid = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    obs_valid = 1'b1;
    tick();
    obs_valid = 1'b0;
  endtask

  task automatic step(input logic [15:0] v);
    cnt_val_i = v; cnt_step_i = 1'b1;
    tick();
    cnt_step_i = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    cnt_val_i = '0; cnt_step_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    expect_reg(4'h0, 8'hFF, "R1 ch1 hi");
    expect_reg(4'h9, 8'hFF, "R1 ch5 lo");
    expect_reg(4'hA, 8'h00, "R1 enables");
    expect_reg(4'hB, 8'h00, "R1 flags");
    expect_irq(1'b0, "R1 irq");

    // R2 byte layout
    bus_wr(4'h0, 8'h12); bus_wr(4'h1, 8'h34);
    bus_wr(4'h8, 8'hAB); bus_wr(4'h9, 8'hCD);
    expect_reg(4'h0, 8'h12, "R2 ch1 hi");
    expect_reg(4'h1, 8'h34, "R2 ch1 lo");
    expect_reg(4'h8, 8'hAB, "R2 ch5 hi");
    expect_reg(4'h9, 8'hCD, "R2 ch5 lo");

    // R3 enable byte
    bus_wr(4'hA, 8'hFF);
    expect_reg(4'hA, 8'hF8, "R3 enables low bits");
    bus_wr(4'hA, 8'h80);
    expect_reg(4'hA, 8'h80, "R3 ch1 at bit7");

    // R6 equal count without strobe
    cnt_val_i = 16'h1234; cnt_step_i = 1'b0; tick();
    expect_reg(4'hB, 8'h00, "R6 no strobe");

    // R4 match with strobe, R9 irq
    step(16'h1234);
    expect_reg(4'hB, 8'h80, "R4 ch1 flag");
    expect_irq(1'b1, "R9 irq on flag");

    // R7 write-0 no effect, write-1 clears
    bus_wr(4'hB, 8'h00);
    expect_reg(4'hB, 8'h80, "R7 write0 keeps");
    bus_wr(4'hB, 8'h80);
    expect_reg(4'hB, 8'h00, "R7 write1 clears");
    expect_irq(1'b0, "R7 irq after clear");

    // R5 disabled channel (ch5 = ABCD, only ch1 enabled)
    step(16'hABCD);
    expect_reg(4'hB, 8'h00, "R5 disabled ch5");

    // R10 new compare value used on next strobe
    bus_wr(4'hA, 8'h40);
    bus_wr(4'h2, 8'h00); bus_wr(4'h3, 8'h10);
    bus_wr(4'h3, 8'h20);
    step(16'h0010);
    expect_reg(4'hB, 8'h00, "R10 old value no match");
    step(16'h0020);
    expect_reg(4'hB, 8'h40, "R10 new value matches");

    // R9 enable withdrawn drops irq, flag stays
    expect_irq(1'b1, "R9 irq ch2");
    bus_wr(4'hA, 8'h00);
    expect_irq(1'b0, "R9 irq dropped");
    expect_reg(4'hB, 8'h40, "R9 flag kept");
    bus_wr(4'hA, 8'h40);
    expect_irq(1'b1, "R9 irq back");
    bus_wr(4'hB, 8'hFF);

    // R8 match and clear in the same cycle
    bus_wr(4'hA, 8'h08);
    wr_en_i = 1'b1; addr_i = 4'hB; wdata_i = 8'h08;
    cnt_val_i = 16'hABCD; cnt_step_i = 1'b1;
    tick();
    wr_en_i = 1'b0; cnt_step_i = 1'b0;
    expect_reg(4'hB, 8'h08, "R8 set wins");

    // R4 two channels at once
    bus_wr(4'hB, 8'hFF);
    bus_wr(4'hA, 8'hF8);
    bus_wr(4'h4, 8'h55); bus_wr(4'h5, 8'h55);
    bus_wr(4'h6, 8'h55); bus_wr(4'h7, 8'h55);
    step(16'h5555);
    expect_reg(4'hB, 8'h30, "R4 ch3 and ch4");

    tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule